// File: doc/BRIEF.md
# Configurable Bidirectional Pad Cell

This block sits between core logic and one bidirectional pad. On the way out, the core's data bit passes through a polarity stage. It then goes to the pad driver either directly or through an output register. A separate three-state control, with its own polarity bit, decides whether the driver is on. On the way in, the pad level is always available to the core without delay. A storage element can also hold a copy of it, and that element works either as a rising-edge flop or as a level-sensitive latch.

Two clock lines reach the cell. The output register and the input storage element each pick one of them on their own. Both storage elements keep working when the pad is not driven, so the cell can double as spare storage. Three electrical option bits (input threshold, edge rate, pull-up) are only held by the cell and reported on a status bus. They have no logical effect.

Top module: `iocell_top`

## Requirements
- R1: With `cfg_out_reg`=0 and the driver on, the pad shows `core_out` XOR `cfg_out_inv` in the same cycle, with no clock involved.
- R2: With `cfg_out_reg`=1 and the driver on, the pad shows the value of `core_out` XOR `cfg_out_inv` captured at the most recent rising edge of the output register's selected clock.
- R3: The driver is off (pad left to external logic) when `core_tri`=1 with `cfg_oe_inv`=0, or `core_tri`=0 with `cfg_oe_inv`=1. For the other two combinations it is on.
- R4: `core_in_direct` always equals the level on the pad, including while the cell itself drives it.
- R5: With `cfg_in_level`=0, `core_in_reg` takes the pad level at each rising edge of the input element's selected clock and holds it between edges.
- R6: With `cfg_in_level`=1, `core_in_reg` follows the pad while the selected input clock is high and keeps the last value while that clock is low.
- R7: Clock select bits `cfg_out_clk` and `cfg_in_clk` choose `clk_a` when 0 and `clk_b` when 1, independently of each other.
- R8: `rst` high at a rising edge of an element's selected clock clears that element to 0. In latch mode, `rst` high clears the latch for as long as it is asserted.
- R9: The output register keeps capturing while the driver is off. Turning the driver on shows its latest captured value without waiting for a clock edge.
- R10: `elec_status` reports {`cfg_cmos`, `cfg_slow`, `cfg_pull`} with bit 2 = threshold, bit 1 = edge rate, bit 0 = pull-up. These bits change no other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | First clock line |
| clk_b | input | 1 | Second clock line |
| rst | input | 1 | Synchronous active-high reset of the storage elements |
| cfg_out_inv | input | 1 | Invert the outgoing data |
| cfg_out_reg | input | 1 | 1: drive from the output register, 0: drive directly |
| cfg_oe_inv | input | 1 | Invert the sense of the three-state control |
| cfg_out_clk | input | 1 | Output register clock select (0 clk_a, 1 clk_b) |
| cfg_in_level | input | 1 | Input element: 0 edge flop, 1 transparent latch |
| cfg_in_clk | input | 1 | Input element clock select (0 clk_a, 1 clk_b) |
| cfg_cmos | input | 1 | Input threshold option bit |
| cfg_slow | input | 1 | Slow edge-rate option bit |
| cfg_pull | input | 1 | Pull-up option bit |
| core_out | input | 1 | Data from the core toward the pad |
| core_tri | input | 1 | Three-state control from the core |
| core_in_direct | output | 1 | Unclocked pad level |
| core_in_reg | output | 1 | Stored pad level |
| elec_status | output | 3 | Electrical option bits |
| pad | inout | 1 | Bidirectional pad |

## Verification
On every `clk_a` edge, assertions check four things: the combinational output path, the one-edge delay of the output register, the direct input following the pad, and the flop capture and reset clearing of the input element while it runs on `clk_a`. Several behaviours depend on how the two clocks are timed against each other, so only the bench scenarios can show them. These are latch transparency and hold, operation from `clk_b`, the high-impedance state against a weak external driver, the register capturing while undriven and then being revealed, and the status bits having no side effects. The bench's per-cycle model covers all of these.

// File: rtl/iocell_pkg.sv
package iocell_pkg;

    typedef enum logic {
        CLK_LINE_A = 1'b0,
        CLK_LINE_B = 1'b1
    } clk_line_e;

    typedef enum logic {
        KEEP_EDGE  = 1'b0,
        KEEP_LEVEL = 1'b1
    } keep_mode_e;

    typedef struct packed {
        logic      invert;
        logic      registered;
        logic      oe_invert;
        clk_line_e clk;
    } out_cfg_t;

    typedef struct packed {
        keep_mode_e mode;
        clk_line_e  clk;
    } in_cfg_t;

    typedef struct packed {
        logic cmos_level;
        logic slow_edge;
        logic pull_high;
    } elec_cfg_t;

    localparam int ELEC_BITS = $bits(elec_cfg_t);

    // Driver is enabled when the control equals its polarity bit.
    function automatic logic driver_on(logic tri_ctl, logic tri_inv);
        return tri_ctl == tri_inv;
    endfunction

endpackage

// File: rtl/iocell_clk_pick.sv
module iocell_clk_pick
    import iocell_pkg::*;
(
    input  logic      clk_a,
    input  logic      clk_b,
    input  clk_line_e sel,
    output logic      clk_out
);
    assign clk_out = (sel == CLK_LINE_B) ? clk_b : clk_a;
endmodule

// File: rtl/iocell_keep.sv
module iocell_keep
    import iocell_pkg::*;
#(
    parameter bit LEVEL_OK = 1'b1,
    parameter bit RST_VAL  = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  keep_mode_e mode,
    input  logic       d,
    output logic       q
);
    logic q_edge;

    always_ff @(posedge clk) begin
        if (rst) q_edge <= RST_VAL;
        else     q_edge <= d;
    end

    generate
        if (LEVEL_OK) begin : g_level
            logic q_level;
            always_latch begin
                if (rst)      q_level = RST_VAL;
                else if (clk) q_level = d;
            end
            assign q = (mode == KEEP_LEVEL) ? q_level : q_edge;
        end else begin : g_edge_only
            logic unused_mode;
            assign unused_mode = mode;
            assign q = q_edge;
        end
    endgenerate
endmodule

// File: rtl/iocell_out_path.sv
module iocell_out_path
    import iocell_pkg::*;
#(
    parameter bit RST_VAL = 1'b0
) (
    input  logic     clk_a,
    input  logic     clk_b,
    input  logic     rst,
    input  out_cfg_t cfg,
    input  logic     core_out,
    input  logic     core_tri,
    output logic     drv_val,
    output logic     drv_en
);
    logic polarized;
    logic reg_clk;
    logic reg_q;

    assign polarized = core_out ^ cfg.invert;

    iocell_clk_pick u_pick (
        .clk_a   (clk_a),
        .clk_b   (clk_b),
        .sel     (cfg.clk),
        .clk_out (reg_clk)
    );

    iocell_keep #(.LEVEL_OK(1'b0), .RST_VAL(RST_VAL)) u_oreg (
        .clk  (reg_clk),
        .rst  (rst),
        .mode (KEEP_EDGE),
        .d    (polarized),
        .q    (reg_q)
    );

    assign drv_val = cfg.registered ? reg_q : polarized;
    assign drv_en  = driver_on(core_tri, cfg.oe_invert);
endmodule

// File: rtl/iocell_in_path.sv
module iocell_in_path
    import iocell_pkg::*;
#(
    parameter bit RST_VAL = 1'b0
) (
    input  logic    clk_a,
    input  logic    clk_b,
    input  logic    rst,
    input  in_cfg_t cfg,
    input  logic    pad_in,
    output logic    direct,
    output logic    stored
);
    logic keep_clk;

    assign direct = pad_in;

    iocell_clk_pick u_pick (
        .clk_a   (clk_a),
        .clk_b   (clk_b),
        .sel     (cfg.clk),
        .clk_out (keep_clk)
    );

    iocell_keep #(.LEVEL_OK(1'b1), .RST_VAL(RST_VAL)) u_ireg (
        .clk  (keep_clk),
        .rst  (rst),
        .mode (cfg.mode),
        .d    (pad_in),
        .q    (stored)
    );
endmodule

// File: rtl/iocell_top.sv
module iocell_top
    import iocell_pkg::*;
#(
    parameter bit OUT_RST_VAL = 1'b0,
    parameter bit IN_RST_VAL  = 1'b0
) (
    input  logic       clk_a,
    input  logic       clk_b,
    input  logic       rst,
    input  logic       cfg_out_inv,
    input  logic       cfg_out_reg,
    input  logic       cfg_oe_inv,
    input  logic       cfg_out_clk,
    input  logic       cfg_in_level,
    input  logic       cfg_in_clk,
    input  logic       cfg_cmos,
    input  logic       cfg_slow,
    input  logic       cfg_pull,
    input  logic       core_out,
    input  logic       core_tri,
    output logic       core_in_direct,
    output logic       core_in_reg,
    output logic [2:0] elec_status,
    inout  wire        pad
);
    out_cfg_t  ocfg;
    in_cfg_t   icfg;
    elec_cfg_t ecfg;
    logic      drv_val;
    logic      drv_en;

    assign ocfg = '{invert: cfg_out_inv, registered: cfg_out_reg,
                    oe_invert: cfg_oe_inv, clk: clk_line_e'(cfg_out_clk)};
    assign icfg = '{mode: keep_mode_e'(cfg_in_level), clk: clk_line_e'(cfg_in_clk)};
    assign ecfg = '{cmos_level: cfg_cmos, slow_edge: cfg_slow, pull_high: cfg_pull};

    iocell_out_path #(.RST_VAL(OUT_RST_VAL)) u_out (
        .clk_a    (clk_a),
        .clk_b    (clk_b),
        .rst      (rst),
        .cfg      (ocfg),
        .core_out (core_out),
        .core_tri (core_tri),
        .drv_val  (drv_val),
        .drv_en   (drv_en)
    );

    assign pad = drv_en ? drv_val : 1'bz;

    iocell_in_path #(.RST_VAL(IN_RST_VAL)) u_in (
        .clk_a  (clk_a),
        .clk_b  (clk_b),
        .rst    (rst),
        .cfg    (icfg),
        .pad_in (pad),
        .direct (core_in_direct),
        .stored (core_in_reg)
    );

    assign elec_status = ecfg;
endmodule

// File: rtl/iocell_chk.sv
module iocell_chk (
    input logic clk_a,
    input logic rst,
    input logic cfg_out_inv,
    input logic cfg_out_reg,
    input logic cfg_oe_inv,
    input logic cfg_out_clk,
    input logic cfg_in_level,
    input logic cfg_in_clk,
    input logic core_out,
    input logic core_tri,
    input logic core_in_direct,
    input logic core_in_reg,
    input wire  pad
);
    // High once the previous clk_a edge saw reset released.
    logic armed = 1'b0;
    always_ff @(posedge clk_a) armed <= !rst;

    a_r1_direct_out: assert property (@(posedge clk_a) disable iff (rst)
        (!cfg_out_reg && core_tri == cfg_oe_inv) |-> (pad == (core_out ^ cfg_out_inv)));

    a_r2_registered_out: assert property (@(posedge clk_a) disable iff (rst)
        (armed && cfg_out_reg && !cfg_out_clk && !$past(cfg_out_clk) && core_tri == cfg_oe_inv)
        |-> (pad == $past(core_out ^ cfg_out_inv)));

    a_r4_direct_in: assert property (@(posedge clk_a) disable iff (rst)
        core_in_direct == pad);

    a_r5_flop_capture: assert property (@(posedge clk_a) disable iff (rst)
        (armed && !cfg_in_level && !cfg_in_clk && !$past(cfg_in_clk))
        |-> (core_in_reg == $past(pad)));

    a_r8_reset_clears: assert property (@(posedge clk_a) disable iff (rst)
        ($past(rst) && !$past(cfg_in_clk) && !cfg_in_clk && !cfg_in_level)
        |-> (core_in_reg == 1'b0));
endmodule

bind iocell_top iocell_chk u_chk (
    .clk_a          (clk_a),
    .rst            (rst),
    .cfg_out_inv    (cfg_out_inv),
    .cfg_out_reg    (cfg_out_reg),
    .cfg_oe_inv     (cfg_oe_inv),
    .cfg_out_clk    (cfg_out_clk),
    .cfg_in_level   (cfg_in_level),
    .cfg_in_clk     (cfg_in_clk),
    .core_out       (core_out),
    .core_tri       (core_tri),
    .core_in_direct (core_in_direct),
    .core_in_reg    (core_in_reg),
    .pad            (pad)
);

// File: tb/iocell_top_tb.sv
module iocell_top_tb;
    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic rst   = 1'b1;
    logic cfg_out_inv = 0, cfg_out_reg = 0, cfg_oe_inv = 0, cfg_out_clk = 0;
    logic cfg_in_level = 0, cfg_in_clk = 0;
    logic cfg_cmos = 0, cfg_slow = 0, cfg_pull = 0;
    logic core_out = 0, core_tri = 1, ext_val = 0;
    logic core_in_direct, core_in_reg;
    logic [2:0] elec_status;
    wire pad;

    assign (weak0, weak1) pad = ext_val;

    iocell_top u_dut (
        .clk_a(clk_a), .clk_b(clk_b), .rst(rst),
        .cfg_out_inv(cfg_out_inv), .cfg_out_reg(cfg_out_reg), .cfg_oe_inv(cfg_oe_inv),
        .cfg_out_clk(cfg_out_clk), .cfg_in_level(cfg_in_level), .cfg_in_clk(cfg_in_clk),
        .cfg_cmos(cfg_cmos), .cfg_slow(cfg_slow), .cfg_pull(cfg_pull),
        .core_out(core_out), .core_tri(core_tri),
        .core_in_direct(core_in_direct), .core_in_reg(core_in_reg),
        .elec_status(elec_status), .pad(pad)
    );

    always #4 clk_a = ~clk_a;                       // 125 MHz
    initial begin #3; forever #10 clk_b = ~clk_b; end

    // Behavioural reference model
    logic m_oq_a = 0, m_oq_b = 0, m_iq_a = 0, m_iq_b = 0, m_iq_lvl = 0;
    logic m_drv, m_pad, m_gate, m_in_exp;
    assign m_drv = cfg_out_reg ? (cfg_out_clk ? m_oq_b : m_oq_a) : (core_out ^ cfg_out_inv);
    assign m_pad = (core_tri == cfg_oe_inv) ? m_drv : ext_val;
    assign m_gate = cfg_in_clk ? clk_b : clk_a;
    assign m_in_exp = cfg_in_level ? m_iq_lvl : (cfg_in_clk ? m_iq_b : m_iq_a);

    always @(posedge clk_a) begin
        if (!cfg_out_clk) m_oq_a <= rst ? 1'b0 : (core_out ^ cfg_out_inv);
        if (!cfg_in_clk)  m_iq_a <= rst ? 1'b0 : m_pad;
    end
    always @(posedge clk_b) begin
        if (cfg_out_clk) m_oq_b <= rst ? 1'b0 : (core_out ^ cfg_out_inv);
        if (cfg_in_clk)  m_iq_b <= rst ? 1'b0 : m_pad;
    end
    always @* begin
        if (rst)         m_iq_lvl = 1'b0;
        else if (m_gate) m_iq_lvl = m_pad;
    end

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit rand_tri = 0, rand_rst = 0, rand_elec = 0;
    string phase = "R8 reset";

    task automatic chk(string what, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", phase, what, act, exp);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk_a);
            #1;
            chk("pad R1/R2/R3/R9", {2'b0, pad}, {2'b0, m_pad});
            chk("direct input R4", {2'b0, core_in_direct}, {2'b0, m_pad});
            chk("stored input R5/R6/R7/R8", {2'b0, core_in_reg}, {2'b0, m_in_exp});
            chk("status R10", elec_status, {cfg_cmos, cfg_slow, cfg_pull});
            core_out = 1'($urandom);
            ext_val  = 1'($urandom);
            if (rand_tri)  core_tri = 1'($urandom);
            if (rand_rst)  rst = ($urandom % 6) == 0;
            if (rand_elec) {cfg_cmos, cfg_slow, cfg_pull} = 3'($urandom);
        end
    endtask

    task automatic hold_reset();
        rst = 1'b1;
        step(1);
    endtask

    task automatic release_reset();
        step(6);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired in phase %s", phase);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R8: reset state, driver off
        step(7);
        rst = 1'b0;
        step(4);

        phase = "R1 direct output";
        core_tri = 0; cfg_oe_inv = 0; cfg_out_reg = 0;
        cfg_out_inv = 0; step(20);
        cfg_out_inv = 1; step(20);

        phase = "R3 three-state polarity";
        rand_tri = 1;
        cfg_oe_inv = 0; step(30);
        cfg_oe_inv = 1; step(30);
        rand_tri = 0;

        phase = "R2 R7 registered output on clk_a";
        hold_reset();
        cfg_out_reg = 1; cfg_out_clk = 0; cfg_oe_inv = 0; core_tri = 0;
        release_reset(); step(30);
        phase = "R2 R7 registered output on clk_b";
        hold_reset();
        cfg_out_clk = 1;
        release_reset(); step(40);

        phase = "R9 register capture while undriven";
        core_tri = 1; step(20);
        core_tri = 0; step(10);
        core_tri = 1; step(13);
        core_tri = 0; step(5);

        phase = "R5 R7 input flop on clk_a";
        hold_reset();
        core_tri = 1; cfg_in_level = 0; cfg_in_clk = 0;
        release_reset(); step(30);
        phase = "R5 R7 input flop on clk_b";
        hold_reset();
        cfg_in_clk = 1;
        release_reset(); step(40);
        phase = "R5 R9 loopback of driven pad";
        core_tri = 0; cfg_out_reg = 0; step(20);
        core_tri = 1;

        phase = "R6 latch on clk_b";
        cfg_in_level = 1; step(40);
        phase = "R6 latch on clk_a";
        hold_reset();
        cfg_in_clk = 0;
        release_reset(); step(30);

        phase = "R8 random reset";
        rand_rst = 1;
        cfg_in_level = 0; step(40);
        cfg_in_level = 1; step(40);
        rand_rst = 0; rst = 0; step(2);

        phase = "R10 status bits";
        rand_elec = 1; rand_tri = 1;
        step(40);
        rand_elec = 0; rand_tri = 0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule